// File: doc/BRIEF.md
# Successive-Approximation Converter Sequencer

This block sequences the digital side of an eight-input, 8-bit successive-approximation converter. It chooses the analogue multiplexer input, presents a trial code to an external DAC, and reads back one comparator bit per decision. It then builds the result from the most significant bit down to the least significant bit, spending three machine cycles on each bit. A finished conversion raises a done flag, which serves as the interrupt, and loads an 8-bit result register.

Software can start a conversion with a one-cycle start strobe, or a board-level start pin can start one on its rising edge. The pin passes through a two-flop synchroniser before use. A start request is dropped, not queued, while a conversion runs or while an unread result is pending. The one exception is a single write that clears the done flag and starts again: it begins a fresh conversion on the currently selected input. A low-power request aborts any conversion in progress and leaves a finished result where it is.

Top module: `adc_seq_ctrl`

## Requirements
- R1: After reset, `busy`, `done`, `result`, `dac_code` and `mux_ch` are all zero.
- R2: A one-cycle `sw_start` pulse, seen while idle with `done` = 0, sets `busy` on the next clock edge, clears `done`, and drives `mux_ch` to the value of `ch_sel`.
- R3: A rising edge on `ext_start` starts a conversion on the third clock edge after the pin rises. Holding the pin high never starts a second conversion.
- R4: A conversion ends on the 24th clock edge, counted from the first edge after the start, at which `mc_en` is 1. On that edge `busy` falls and `done` rises together, and the two flags are never 1 at the same time.
- R5: The 8-bit result is decided MSB first. Each trial bit is kept when `cmp_hi` is 1 on its deciding edge. With `cmp_hi` = (input >= `dac_code`), `result` equals the input code.
- R6: A start request, from software or the pin, made while `busy` is 1 is lost. The running conversion completes with its original channel and result.
- R7: A start request made while `done` is 1, without a clear in the same cycle, is lost. `busy` stays 0 and `result` is unchanged.
- R8: `sw_clr_done` and `sw_start` asserted in the same cycle start a new conversion on `ch_sel`.
- R9: `lp_req` aborts a running conversion on the next edge: `busy` goes to 0, `dac_code` goes to 0, `result` is unchanged, and no start is accepted while `lp_req` is 1. A `done` flag that is already 1 stays 1.
- R10: A `sw_clr_done` pulse clears `done` and leaves `result` unchanged.
- R11: `mux_ch` takes `ch_sel` on the start edge and holds it for the whole conversion. Changes to `ch_sel` during the conversion have no effect.
- R12: While `mc_en` is 0 the conversion is frozen: `dac_code` holds and `busy` stays 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| mc_en | input | 1 | Machine-cycle enable; one conversion step per high cycle |
| ext_start | input | 1 | Asynchronous start pin, rising-edge active |
| sw_start | input | 1 | Software start strobe |
| sw_clr_done | input | 1 | Software clear of the done flag |
| ch_sel | input | 3 | Requested input channel |
| lp_req | input | 1 | Idle/power-down entry request |
| cmp_hi | input | 1 | Comparator: selected input >= trial code |
| mux_ch | output | 3 | Channel driven to the analogue multiplexer |
| dac_code | output | 8 | Trial code for the DAC; 0 while idle |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | Conversion finished, result valid |
| result | output | 8 | Converted value |

## Verification
A software start appears on `busy` and `mux_ch` one edge later. A pin start appears on the third edge after the pin rises, so the bench checks that `busy` is still low after two edges and high after three. The bench drives every input just after the falling edge, records the `mc_en` value that the next rising edge will use, and counts those values. It expects `busy` high through 23 counted enables and `done` high with the result right after the 24th, whatever the enable pattern (steady, every third cycle, random or stalled). Ignored starts, clears and aborts are checked one or two edges after the stimulus, by reading `busy`, `done` and the unchanged `result` at the ports.

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;
   typedef enum logic {
      SAR_IDLE = 1'b0,
      SAR_RUN  = 1'b1
   } sar_state_e;

   function automatic int unsigned conv_len(input int unsigned res_w, input int unsigned cyc_per_bit);
      return res_w * cyc_per_bit;
   endfunction
endpackage

// File: rtl/adc_start_sync.sv
module adc_start_sync #(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          RISE_ACTIVE = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pin_async,
   output logic edge_pulse
);
   logic [SYNC_STAGES-1:0] sync_q;
   logic                   prev_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sync_q <= '0;
         prev_q <= 1'b0;
      end else begin
         sync_q <= {sync_q[SYNC_STAGES-2:0], pin_async};
         prev_q <= sync_q[SYNC_STAGES-1];
      end
   end

   generate
      if (RISE_ACTIVE) begin : g_rise
         assign edge_pulse = sync_q[SYNC_STAGES-1] & ~prev_q;
      end else begin : g_fall
         assign edge_pulse = ~sync_q[SYNC_STAGES-1] & prev_q;
      end
   endgenerate
endmodule

// File: rtl/adc_start_gate.sv
module adc_start_gate (
   input  logic sw_start,
   input  logic pin_pulse,
   input  logic busy,
   input  logic done,
   input  logic clr_done,
   input  logic lp_req,
   output logic start_go
);
   logic any_req;
   logic slot_free;

   always_comb begin
      any_req   = sw_start | pin_pulse;
      slot_free = ~busy & (~done | clr_done) & ~lp_req;
      start_go  = any_req & slot_free;
   end
endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core
   import adc_seq_pkg::*;
#(
   parameter int unsigned RES_W       = 8,
   parameter int unsigned CYC_PER_BIT = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             abort,
   input  logic             step_en,
   input  logic             cmp_hi,
   output logic             running,
   output logic             finish,
   output logic [RES_W-1:0] final_code,
   output logic [RES_W-1:0] trial_code
);
   localparam int unsigned IDX_W = (RES_W > 1) ? $clog2(RES_W) : 1;
   localparam int unsigned PH_W  = (CYC_PER_BIT > 1) ? $clog2(CYC_PER_BIT) : 1;
   localparam logic [PH_W-1:0]  PH_LAST  = PH_W'(CYC_PER_BIT - 1);
   localparam logic [IDX_W-1:0] IDX_TOP  = IDX_W'(RES_W - 1);
   localparam logic [RES_W-1:0] ONE_HOT0 = {{(RES_W-1){1'b0}}, 1'b1};

   sar_state_e       state_q;
   logic [PH_W-1:0]  phase_q;
   logic [IDX_W-1:0] idx_q;
   logic [RES_W-1:0] sar_q;

   logic             decide;
   logic             last_bit;
   logic [RES_W-1:0] cur_mask;
   logic [RES_W-1:0] kept;
   logic [RES_W-1:0] next_sar;

   always_comb begin
      decide   = (state_q == SAR_RUN) && step_en && (phase_q == PH_LAST) && !abort;
      last_bit = (idx_q == '0);
      cur_mask = ONE_HOT0 << idx_q;
      kept     = cmp_hi ? sar_q : (sar_q & ~cur_mask);
      next_sar = last_bit ? kept : (kept | (cur_mask >> 1));
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= SAR_IDLE;
         phase_q <= '0;
         idx_q   <= '0;
         sar_q   <= '0;
      end else if (abort) begin
         state_q <= SAR_IDLE;
         phase_q <= '0;
         idx_q   <= '0;
         sar_q   <= '0;
      end else if (start) begin
         state_q <= SAR_RUN;
         phase_q <= '0;
         idx_q   <= IDX_TOP;
         sar_q   <= ONE_HOT0 << IDX_TOP;
      end else if (state_q == SAR_RUN && step_en) begin
         if (phase_q == PH_LAST) begin
            phase_q <= '0;
            if (last_bit) begin
               state_q <= SAR_IDLE;
               sar_q   <= '0;
            end else begin
               idx_q <= idx_q - 1'b1;
               sar_q <= next_sar;
            end
         end else begin
            phase_q <= phase_q + 1'b1;
         end
      end
   end

   assign running    = (state_q == SAR_RUN);
   assign finish     = decide && last_bit;
   assign final_code = next_sar;
   assign trial_code = sar_q;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl #(
   parameter int unsigned RES_W       = 8,
   parameter int unsigned CH_W        = 3,
   parameter int unsigned CYC_PER_BIT = 3,
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          EXT_RISE    = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mc_en,
   input  logic             ext_start,
   input  logic             sw_start,
   input  logic             sw_clr_done,
   input  logic [CH_W-1:0]  ch_sel,
   input  logic             lp_req,
   input  logic             cmp_hi,
   output logic [CH_W-1:0]  mux_ch,
   output logic [RES_W-1:0] dac_code,
   output logic             busy,
   output logic             done,
   output logic [RES_W-1:0] result
);
   generate
      if (RES_W < 2) begin : g_bad_res
         $error("RES_W must be at least 2");
      end
      if (CH_W < 1) begin : g_bad_ch
         $error("CH_W must be at least 1");
      end
      if (CYC_PER_BIT < 1) begin : g_bad_cyc
         $error("CYC_PER_BIT must be at least 1");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
   endgenerate

   logic             pin_pulse;
   logic             start_go;
   logic             core_run;
   logic             core_fin;
   logic [RES_W-1:0] core_final;
   logic [RES_W-1:0] core_trial;
   logic             done_q;
   logic [RES_W-1:0] result_q;
   logic [CH_W-1:0]  ch_q;

   adc_start_sync #(
      .SYNC_STAGES(SYNC_STAGES),
      .RISE_ACTIVE(EXT_RISE)
   ) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .pin_async (ext_start),
      .edge_pulse(pin_pulse)
   );

   adc_start_gate u_gate (
      .sw_start (sw_start),
      .pin_pulse(pin_pulse),
      .busy     (core_run),
      .done     (done_q),
      .clr_done (sw_clr_done),
      .lp_req   (lp_req),
      .start_go (start_go)
   );

   adc_sar_core #(
      .RES_W      (RES_W),
      .CYC_PER_BIT(CYC_PER_BIT)
   ) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start_go),
      .abort     (lp_req),
      .step_en   (mc_en),
      .cmp_hi    (cmp_hi),
      .running   (core_run),
      .finish    (core_fin),
      .final_code(core_final),
      .trial_code(core_trial)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         done_q   <= 1'b0;
         result_q <= '0;
         ch_q     <= '0;
      end else begin
         if (core_fin) begin
            done_q   <= 1'b1;
            result_q <= core_final;
         end else if (sw_clr_done || start_go) begin
            done_q <= 1'b0;
         end
         if (start_go) begin
            ch_q <= ch_sel;
         end
      end
   end

   assign mux_ch   = ch_q;
   assign dac_code = core_trial;
   assign busy     = core_run;
   assign done     = done_q;
   assign result   = result_q;
endmodule

// File: rtl/adc_seq_chk.sv
module adc_seq_chk #(
   parameter int unsigned RES_W       = 8,
   parameter int unsigned CH_W        = 3,
   parameter int unsigned CYC_PER_BIT = 3
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mc_en,
   input logic             lp_req,
   input logic             sw_clr_done,
   input logic [CH_W-1:0]  mux_ch,
   input logic [RES_W-1:0] dac_code,
   input logic             busy,
   input logic             done,
   input logic [RES_W-1:0] result
);
   localparam int unsigned CONV  = adc_seq_pkg::conv_len(RES_W, CYC_PER_BIT);
   localparam int unsigned CNT_W = $clog2(CONV + 2);

   logic [CNT_W-1:0] mc_cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) mc_cnt <= '0;
      else if (!busy) mc_cnt <= '0;
      else if (mc_en) mc_cnt <= mc_cnt + 1'b1;
   end

   p_flags_excl_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !(busy && done));

   p_done_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> (mc_cnt == CNT_W'(CONV)));

   p_done_after_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(done) |-> $fell(busy));

   p_result_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (done && $past(done)) |-> $stable(result));

   p_ch_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(mux_ch));

   p_lp_abort_r9: assert property (@(posedge clk) disable iff (!rst_n)
      lp_req |=> (!busy && dac_code == '0));

   p_lp_keep_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && lp_req && !sw_clr_done) |=> done);

   p_stall_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !mc_en && !lp_req) |=> (busy && $stable(dac_code)));
endmodule

bind adc_seq_ctrl adc_seq_chk #(
   .RES_W      (RES_W),
   .CH_W       (CH_W),
   .CYC_PER_BIT(CYC_PER_BIT)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .mc_en      (mc_en),
   .lp_req     (lp_req),
   .sw_clr_done(sw_clr_done),
   .mux_ch     (mux_ch),
   .dac_code   (dac_code),
   .busy       (busy),
   .done       (done),
   .result     (result)
);

// File: tb/adc_seq_ctrl_bench.sv
module adc_seq_ctrl_bench;
   localparam int CONV = 24;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       mc_en = 1'b0;
   logic       ext_start = 1'b0;
   logic       sw_start = 1'b0;
   logic       sw_clr_done = 1'b0;
   logic [2:0] ch_sel = 3'd0;
   logic       lp_req = 1'b0;
   logic       cmp_hi;
   logic [2:0] mux_ch;
   logic [7:0] dac_code;
   logic       busy;
   logic       done;
   logic [7:0] result;

   logic [7:0] vin [8];
   int n_tests = 0;
   int n_fail  = 0;
   int mc_mode = 0;
   int div_c   = 0;
   bit finished = 0;

   always #2 clk = ~clk;

   assign cmp_hi = (vin[mux_ch] >= dac_code);

   adc_seq_ctrl u_adc_seq_ctrl (
      .clk(clk), .rst_n(rst_n), .mc_en(mc_en), .ext_start(ext_start),
      .sw_start(sw_start), .sw_clr_done(sw_clr_done), .ch_sel(ch_sel),
      .lp_req(lp_req), .cmp_hi(cmp_hi), .mux_ch(mux_ch), .dac_code(dac_code),
      .busy(busy), .done(done), .result(result)
   );

   task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   task automatic step();
      @(negedge clk);
      case (mc_mode)
         0: mc_en = 1'b1;
         1: mc_en = 1'($urandom % 2);
         2: begin div_c = (div_c + 1) % 3; mc_en = (div_c == 0); end
         default: mc_en = 1'b0;
      endcase
   endtask

   task automatic sw_go(input int c);
      ch_sel = 3'(c);
      sw_start = 1'b1;
      step();
      sw_start = 1'b0;
   endtask

   task automatic clr_done();
      sw_clr_done = 1'b1;
      step();
      sw_clr_done = 1'b0;
   endtask

   // counts enables seen by each rising edge; expects completion on the 24th
   task automatic run_conv(input int c, input int poke, input int other);
      int cnt = 0;
      int guard = 0;
      bit bad_b = 0;
      bit bad_m = 0;
      while (cnt < CONV && guard < 600) begin
         bit pre;
         pre = mc_en;
         if (guard == poke) begin sw_start = 1'b1; ch_sel = 3'(other); end
         step();
         sw_start = 1'b0;
         guard++;
         if (pre) cnt++;
         if (cnt < CONV) begin
            if (!busy || done) bad_b = 1;
            if (mux_ch != 3'(c)) bad_m = 1;
         end
      end
      chk(!bad_b && !busy && done, "R4", "busy/done over 24 enables", {busy, done}, 1);
      chk(result == vin[c], "R5", "result of channel", result, vin[c]);
      if (poke >= 0) begin
         chk(!bad_m, "R11", "mux_ch held despite ch_sel change", mux_ch, c);
         chk(result == vin[c], "R6", "start while busy lost", result, vin[c]);
      end
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
         $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'h5A17));
      for (int i = 0; i < 8; i++) vin[i] = 8'($urandom);
      repeat (3) @(negedge clk);
      chk(!busy && !done && result == 0 && dac_code == 0 && mux_ch == 0, "R1", "reset outputs",
          {busy, done, result}, 0);
      rst_n = 1'b1;
      step();

      // R2 / R5 / R10: random conversions under varied enable patterns
      for (int k = 0; k < 8; k++) begin
         int c;
         c = int'($urandom % 8);
         if (k == 0) vin[c] = 8'h00;
         if (k == 1) vin[c] = 8'hFF;
         mc_mode = k % 3;
         sw_go(c);
         chk(busy && !done && mux_ch == 3'(c), "R2", "software start", mux_ch, c);
         run_conv(c, -1, 0);
         begin
            logic [7:0] keep;
            keep = result;
            clr_done();
            chk(!done && result == keep, "R10", "clear keeps result", result, keep);
         end
      end
      mc_mode = 0;

      // R6 / R11: start request and channel change mid-conversion
      sw_go(2);
      run_conv(2, 10, 6);
      clr_done();

      // R3: pin start, two-flop sync plus edge detect
      ch_sel = 3'd5;
      ext_start = 1'b1;
      step();
      step();
      chk(!busy, "R3", "pin start not before third edge", busy, 0);
      step();
      chk(busy && mux_ch == 3'd5, "R3", "pin start on third edge", busy, 1);
      run_conv(5, -1, 0);
      clr_done();
      repeat (6) step();
      chk(!busy && !done, "R3", "held pin does not retrigger", busy, 0);
      ext_start = 1'b0;
      step();

      // R7: start while done pending is lost
      sw_go(1);
      run_conv(1, -1, 0);
      begin
         logic [7:0] keep;
         keep = result;
         ch_sel = 3'd4;
         sw_start = 1'b1;
         step();
         sw_start = 1'b0;
         step();
         chk(!busy && done && result == keep && mux_ch == 3'd1, "R7", "start with done set ignored",
             busy, 0);
      end

      // R8: clear and start in one write
      ch_sel = 3'd7;
      sw_clr_done = 1'b1;
      sw_start = 1'b1;
      step();
      sw_clr_done = 1'b0;
      sw_start = 1'b0;
      chk(busy && !done && mux_ch == 3'd7, "R8", "clear+start begins conversion", busy, 1);
      run_conv(7, -1, 0);
      clr_done();

      // R9: low-power abort
      begin
         logic [7:0] keep;
         keep = result;
         sw_go(3);
         repeat (5) step();
         lp_req = 1'b1;
         step();
         chk(!busy && !done && dac_code == 0 && result == keep, "R9", "abort on low-power", busy, 0);
         sw_start = 1'b1;
         step();
         sw_start = 1'b0;
         step();
         chk(!busy, "R9", "no start during low-power", busy, 0);
         lp_req = 1'b0;
         step();
         sw_go(3);
         run_conv(3, -1, 0);
         keep = result;
         lp_req = 1'b1;
         step();
         lp_req = 1'b0;
         step();
         chk(done && result == keep, "R9", "done kept on low-power", done, 1);
         clr_done();
      end

      // R12: stall with machine-cycle enable low
      begin
         logic [7:0] held;
         mc_mode = 3;
         sw_go(0);
         step();
         held = dac_code;
         repeat (10) step();
         chk(busy && dac_code == held, "R12", "stalled conversion frozen", dac_code, held);
         mc_mode = 0;
         run_conv(0, -1, 0);
         clr_done();
      end

      finished = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule